// File: doc/BRIEF.md
# Three-Domain Ratio Clock Enable Generator

The block runs on one fast input clock and produces three clock-enable streams: one for the core (system) domain, one for ordinary peripherals and one for the external bus interface. DMA-style bus masters use the system enable. Each stream is a one-cycle pulse repeated every N input cycles, where N is a power of two chosen by a 3-bit code. The three codes sit side by side in one 9-bit value that is loaded through a single-cycle write strobe.

The system ratio always wins. If the peripheral or bus code asks for a faster rate than the system code, that stream runs at the system rate instead. A newly written setting is queued and a pending flag is raised. The setting is not applied while the bus-busy input is high. In the first input-clock cycle where the bus is idle, all three streams switch together. A shared phase counter restarts at the switch, so every new stream begins with a complete period. All streams stay phase-aligned: each pulse of a slower stream coincides with a pulse of every faster stream.

Top module: `clk_ratio_gen`

## Requirements
- R1: While reset is held, and after reset until the first write, all three enables are high on every cycle and the pending flag is low.
- R2: The write data splits into system code on bits [2:0], peripheral code on bits [5:3] and bus code on bits [8:6]. Code c of 0 to 3 gives a period of 2^c input cycles. Codes 4 to 7 all give a period of 16. Each enable is high for exactly one cycle per period.
- R3: The peripheral and bus periods used are the larger of their own coded period and the system period. Whenever the peripheral or bus enable is high, the system enable is high in the same cycle.
- R4: The pending flag is high from the clock edge that samples a write. While the bus-busy input is high, the queued setting is not applied and the enables keep their previous periods.
- R5: On the first clock edge where the pending flag is high, bus-busy is low and no new write is sampled, the queued setting takes effect and the pending flag falls at that same edge.
- R6: After a setting takes effect, each enable first goes high exactly one full new period after the switch edge. That is, it is high in cycle n (n = 0 is the cycle following the switch edge) exactly when (n+1) is a multiple of its period.
- R7: A write sampled while a setting is pending replaces the queued setting. Only the last one written is applied.
- R8: A write sampled in a cycle that would otherwise apply the queued setting keeps the flag pending, and the switch moves to the next idle cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock that all enables are derived from |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en_i | input | 1 | Write strobe for the ratio setting |
| wr_data_i | input | 9 | Ratio codes: bus [8:6], peripheral [5:3], system [2:0] |
| bus_busy_i | input | 1 | High while a bus cycle is in progress; holds off the switch |
| sys_ce_o | output | 1 | System-domain clock enable |
| per_ce_o | output | 1 | Peripheral-domain clock enable |
| bus_ce_o | output | 1 | External-bus-domain clock enable |
| pending_o | output | 1 | High while a written setting waits to be applied |

## Verification
The hardest situations to reach are the hand-offs around the deferred switch. These are a write that lands while an earlier setting is still queued behind a busy bus, and a write that lands in the very cycle the queued setting would otherwise have been applied. The stimulus holds bus-busy high across two back-to-back writes and then releases it. Separately, with the bus idle, it issues two writes on consecutive cycles. A scoreboard queue replaces its newest entry whenever the pending flag was already high at the write. The monitor pops an entry only when the pending flag falls, and then checks every cycle of each enable against the popped periods, counted from the switch.

// File: rtl/clk_ratio_pkg.sv
package clk_ratio_pkg;
  localparam int unsigned CODE_W    = 3;
  localparam int unsigned NUM_DOM   = 3;
  localparam int unsigned MAX_SHIFT = 4;
  localparam int unsigned SHIFT_W   = $clog2(MAX_SHIFT + 1);
  localparam int unsigned CNT_W     = MAX_SHIFT;

  localparam int unsigned DOM_SYS = 0;
  localparam int unsigned DOM_PER = 1;
  localparam int unsigned DOM_BUS = 2;

  typedef struct packed {
    logic [CODE_W-1:0] bus;
    logic [CODE_W-1:0] per;
    logic [CODE_W-1:0] sys;
  } ratio_t;

  typedef logic [SHIFT_W-1:0] shift_t;

  function automatic shift_t code_to_shift(logic [CODE_W-1:0] code);
    if (code > CODE_W'(MAX_SHIFT)) return SHIFT_W'(MAX_SHIFT);
    return SHIFT_W'(code);
  endfunction

  function automatic shift_t slower_of(shift_t a, shift_t b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/ratio_rst_sync.sv
module ratio_rst_sync (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_no
);
  logic [1:0] sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b00;
    else         sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_no = sync_q[1];
endmodule

// File: rtl/ratio_ctrl.sv
module ratio_ctrl
  import clk_ratio_pkg::*;
(
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  ratio_t                    wr_data_i,
  input  logic                      bus_busy_i,
  output logic                      pending_o,
  output logic                      apply_o,
  output shift_t [NUM_DOM-1:0]      shift_o
);
  ratio_t active_q, active_d;
  ratio_t queued_q, queued_d;
  logic   pend_q,   pend_d;
  shift_t sys_shift;

  // switch only when idle and no fresh write competes in this cycle
  assign apply_o = pend_q && !bus_busy_i && !wr_en_i;

  always_comb begin
    active_d = active_q;
    queued_d = queued_q;
    pend_d   = pend_q;
    if (wr_en_i) begin
      queued_d = wr_data_i;
      pend_d   = 1'b1;
    end else if (apply_o) begin
      active_d = queued_q;
      pend_d   = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= '0;
      queued_q <= '0;
      pend_q   <= 1'b0;
    end else begin
      active_q <= active_d;
      queued_q <= queued_d;
      pend_q   <= pend_d;
    end
  end

  // system ratio has priority: slower domains never outrun it
  assign sys_shift         = code_to_shift(active_q.sys);
  assign shift_o[DOM_SYS]  = sys_shift;
  assign shift_o[DOM_PER]  = slower_of(code_to_shift(active_q.per), sys_shift);
  assign shift_o[DOM_BUS]  = slower_of(code_to_shift(active_q.bus), sys_shift);
  assign pending_o         = pend_q;
endmodule

// File: rtl/phase_counter.sv
module phase_counter #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    if (restart_i) cnt_d = '0;
    else           cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/ce_decode.sv
module ce_decode #(
  parameter int unsigned CNT_W   = 4,
  parameter int unsigned SHIFT_W = 3
) (
  input  logic [CNT_W-1:0]   cnt_i,
  input  logic [SHIFT_W-1:0] shift_i,
  output logic               ce_o
);
  logic [CNT_W-1:0] mask;

  always_comb begin
    for (int i = 0; i < int'(CNT_W); i++) begin
      mask[i] = (i < int'(shift_i));
    end
  end

  // pulse on the last count of each 2^shift window
  assign ce_o = ((cnt_i & mask) == mask);
endmodule

// File: rtl/clk_ratio_gen.sv
module clk_ratio_gen
  import clk_ratio_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  wr_en_i,
  input  logic [3*CODE_W-1:0]   wr_data_i,
  input  logic                  bus_busy_i,
  output logic                  sys_ce_o,
  output logic                  per_ce_o,
  output logic                  bus_ce_o,
  output logic                  pending_o
);
  logic                  rst_n_sync;
  logic                  apply;
  shift_t [NUM_DOM-1:0]  shift;
  logic [CNT_W-1:0]      phase;
  logic [NUM_DOM-1:0]    ce;

  ratio_rst_sync u_rst (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .rst_no (rst_n_sync)
  );

  ratio_ctrl u_ctrl (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_sync),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (ratio_t'(wr_data_i)),
    .bus_busy_i (bus_busy_i),
    .pending_o  (pending_o),
    .apply_o    (apply),
    .shift_o    (shift)
  );

  phase_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_n_sync),
    .restart_i (apply),
    .cnt_o     (phase)
  );

  for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
    ce_decode #(.CNT_W(CNT_W), .SHIFT_W(SHIFT_W)) u_dec (
      .cnt_i   (phase),
      .shift_i (shift[d]),
      .ce_o    (ce[d])
    );
  end

  assign sys_ce_o = ce[DOM_SYS];
  assign per_ce_o = ce[DOM_PER];
  assign bus_ce_o = ce[DOM_BUS];
endmodule

// File: rtl/clk_ratio_gen_chk.sv
module clk_ratio_gen_chk (
  input logic clk_i,
  input logic rst_n,
  input logic wr_en_i,
  input logic bus_busy_i,
  input logic sys_ce_o,
  input logic per_ce_o,
  input logic bus_ce_o,
  input logic pending_o
);
  p_per_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    per_ce_o |-> sys_ce_o);

  p_bus_aligned_r3: assert property (@(posedge clk_i) disable iff (!rst_n)
    bus_ce_o |-> sys_ce_o);

  p_write_pends_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    wr_en_i |=> pending_o);

  p_busy_holds_r4: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pending_o && bus_busy_i) |=> pending_o);

  p_idle_applies_r5: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pending_o && !bus_busy_i && !wr_en_i) |=> !pending_o);

  p_write_defers_r8: assert property (@(posedge clk_i) disable iff (!rst_n)
    (pending_o && wr_en_i) |=> pending_o);

  p_no_spurious_r1: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!pending_o && !wr_en_i) |=> !pending_o);
endmodule

bind clk_ratio_gen clk_ratio_gen_chk u_chk (
  .clk_i      (clk_i),
  .rst_n      (rst_n_sync),
  .wr_en_i    (wr_en_i),
  .bus_busy_i (bus_busy_i),
  .sys_ce_o   (sys_ce_o),
  .per_ce_o   (per_ce_o),
  .bus_ce_o   (bus_ce_o),
  .pending_o  (pending_o)
);

// File: tb/clk_ratio_gen_tb_top.sv
module clk_ratio_gen_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       wr_en_i;
  logic [8:0] wr_data_i;
  logic       bus_busy_i;
  logic       sys_ce_o, per_ce_o, bus_ce_o, pending_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit mon_on  = 1'b0;
  bit done    = 1'b0;

  typedef struct { int sp; int pp; int bp; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  clk_ratio_gen dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_data_i(wr_data_i),
    .bus_busy_i(bus_busy_i), .sys_ce_o(sys_ce_o), .per_ce_o(per_ce_o),
    .bus_ce_o(bus_ce_o), .pending_o(pending_o)
  );

  function automatic int period_of(int code);
    return (code >= 4) ? 16 : (1 << code);
  endfunction

  task automatic check(string tag, int act, int exp_v);
    n_tests++;
    if (act != exp_v) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp_v);
    end
  endtask

  // driver: pushes the expected periods; a write while pending replaces the newest
  task automatic write_ratio(int s, int p, int b);
    exp_t e;
    e.sp = period_of(s);
    e.pp = (period_of(p) > e.sp) ? period_of(p) : e.sp;
    e.bp = (period_of(b) > e.sp) ? period_of(b) : e.sp;
    if (pending_o && exp_q.size() > 0) void'(exp_q.pop_back());
    exp_q.push_back(e);
    wr_data_i = {3'(b), 3'(p), 3'(s)};
    wr_en_i   = 1'b1;
    @(posedge clk_i); #1;
    wr_en_i   = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk_i);
    #1;
  endtask

  // monitor: pops on the switch and checks every enable against the popped periods
  exp_t cur = '{sp: 1, pp: 1, bp: 1};
  int   ncyc = 0;
  bit   prev_pend = 1'b0;
  always @(negedge clk_i) begin
    if (mon_on) begin
      if (prev_pend && !pending_o) begin
        if (exp_q.size() == 0) check("R5 switch without queued setting", 1, 0);
        else cur = exp_q.pop_front();
        ncyc = 0;
      end else begin
        ncyc++;
      end
      check((ncyc < cur.sp) ? "R6 sys first pulse" : "R2 sys period",
            int'(sys_ce_o), int'(((ncyc + 1) % cur.sp) == 0));
      check((ncyc < cur.pp) ? "R6 per first pulse" : "R3 per period",
            int'(per_ce_o), int'(((ncyc + 1) % cur.pp) == 0));
      check((ncyc < cur.bp) ? "R6 bus first pulse" : "R3 bus period",
            int'(bus_ce_o), int'(((ncyc + 1) % cur.bp) == 0));
      prev_pend = pending_o;
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      n_fail++; n_tests++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_data_i = '0; bus_busy_i = 1'b0;
    repeat (3) @(negedge clk_i);
    // R1: enables high every cycle during reset, nothing pending
    check("R1 sys in reset", int'(sys_ce_o), 1);
    check("R1 bus in reset", int'(bus_ce_o), 1);
    check("R1 pending in reset", int'(pending_o), 0);
    rst_ni = 1'b1;
    idle(4);
    mon_on = 1'b1;
    idle(6);
    check("R1 pending after reset", int'(pending_o), 0);

    // R2: plain ratios, bus idle
    write_ratio(1, 2, 3);
    @(negedge clk_i); check("R4 pending after write", int'(pending_o), 1);
    @(negedge clk_i); check("R5 applied next idle cycle", int'(pending_o), 0);
    idle(40);

    // R3: peripheral and bus requests faster than system get clamped
    write_ratio(3, 1, 0);
    idle(40);

    // R2: reserved codes behave as divide by 16
    write_ratio(0, 5, 7);
    idle(50);

    // R4/R5: held off by a busy bus
    #0 bus_busy_i = 1'b1;
    write_ratio(2, 2, 2);
    idle(30);
    @(negedge clk_i); check("R4 held while busy", int'(pending_o), 1);
    #1 bus_busy_i = 1'b0;
    @(negedge clk_i); check("R5 applied once idle", int'(pending_o), 0);
    idle(30);

    // R7: two writes queued behind busy bus, only the last is applied
    bus_busy_i = 1'b1;
    write_ratio(4, 4, 4);
    idle(5);
    write_ratio(1, 3, 2);
    idle(10);
    bus_busy_i = 1'b0;
    idle(40);

    // R8: write in the cycle that would apply keeps it pending one more cycle
    write_ratio(2, 4, 1);
    write_ratio(0, 1, 2);
    @(negedge clk_i); check("R8 still pending after second write", int'(pending_o), 1);
    @(negedge clk_i); check("R8 applied after deferral", int'(pending_o), 0);
    idle(40);

    // back to all divide by 1
    write_ratio(0, 0, 0);
    idle(10);
    check("R7 queue drained", exp_q.size(), 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule